// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block sits beside the register file of a serial port. It takes the raw interrupt sources of the port: receive-line errors, the receive trigger and timeout, transmit-FIFO empty and the modem-signal deltas. It masks each source with its enable bit, drives one level-sensitive interrupt line and forms the identification byte that software reads to learn which source to service first. Five sources share a fixed ranking. The byte carries a four-bit code for the winner and a pending flag that is low when something is pending. Its upper two bits show whether the FIFOs are on.

The transmit-empty source has no status bit of its own, so the block keeps a pending flag for it. The flag is raised when the transmit FIFO drains, or when software turns on the transmit-empty enable while the FIFO is already empty. It is dropped by a write to the transmit holding register, or by a read of the identification byte that reports transmit-empty as the winner. The byte returned for a read is latched on the read strobe, so the clear caused by that same read never alters the value handed back. Every other source is cleared by the register that owns it, outside this block.

Top module: `irq_id_unit`

## Requirements
- R1: When several enabled sources are active, the reported one is chosen in this order, highest first: line status, receive data, character timeout, transmit empty, modem status.
- R2: The low nibble of the identification byte is 0x6 for line status, 0x4 for receive data, 0xC for timeout, 0x2 for transmit empty, 0x0 for modem status and 0x1 when nothing is pending.
- R3: `irq` is high exactly when at least one enabled source is active, and bit 0 of `idLive` is then 0.
- R4: Bits 7:6 of the identification byte are 11 when `fifoEn` is 1 and 00 otherwise; bits 5:4 are always 0.
- R5: The line-status source is active when `ieMask[2]` is 1 and any bit of `lineErr` (bit 0 overrun, 1 parity, 2 framing, 3 break) is 1.
- R6: The receive-data source (`rxTrigHit`) and the timeout source (`rxTimeout`) are both masked by `ieMask[0]`.
- R7: The transmit-empty pending flag is set one cycle after `txFifoEmpty` rises, or one cycle after `ieMask[1]` rises while `txFifoEmpty` is 1. The source is reported only while `ieMask[1]` is 1.
- R8: The transmit-empty pending flag is cleared one cycle after `thrWrite`, or one cycle after `iirRead` in a cycle where transmit empty is the reported source. A set event in the same cycle takes precedence over the clear.
- R9: The modem source is active when `ieMask[3]` is 1 and any bit of `modemDelta` is 1.
- R10: `idRead` takes the value of `idLive` present in a cycle with `iirRead` high and holds it until the next read.
- R11: After reset the transmit-empty flag is clear, `idRead` is 0x01, and with no enabled source `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ieMask | input | 4 | Enables: bit0 receive data/timeout, bit1 transmit empty, bit2 line status, bit3 modem |
| lineErr | input | 4 | Receive error flags: overrun, parity, framing, break |
| rxTrigHit | input | 1 | Receive FIFO at or above its trigger level |
| rxTimeout | input | 1 | Character timeout condition |
| txFifoEmpty | input | 1 | Transmit FIFO is empty |
| modemDelta | input | 4 | Modem-signal change flags |
| fifoEn | input | 1 | FIFOs enabled |
| iirRead | input | 1 | One-cycle strobe: identification byte read |
| thrWrite | input | 1 | One-cycle strobe: transmit holding register written |
| irq | output | 1 | Level interrupt request |
| idLive | output | 8 | Current identification byte |
| idRead | output | 8 | Identification byte latched on the last read |

## Verification
The two functions that can land in the same cycle are the clear of the transmit-empty flag by an identification read that reports it, and a fresh set event from the FIFO draining or the enable rising. The bench provokes this directly: it first lowers `txFifoEmpty`, then raises it in the very cycle that carries `iirRead`. It also lets random stimulus hit the case many times. The bench's own flag model says the set wins, so the latched byte must show 0x2 and the live byte must keep showing transmit empty afterwards. A read that hits only the clear must leave the next lower source or 0x1 visible.

// File: rtl/irqid_pkg.sv
package irqid_pkg;

  localparam int NUM_SRC = 5;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_TXEMPTY = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } idCode_e;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic txPend;   // transmit-empty pending flag
    logic capture;  // latch the identification byte this cycle
  } ctlStrobes_t;

  // Code for each priority slot, slot 0 ranks highest.
  function automatic logic [3:0] slotCode(input int slot);
    case (slot)
      0:       slotCode = ID_LINE;
      1:       slotCode = ID_RXDATA;
      2:       slotCode = ID_TIMEOUT;
      3:       slotCode = ID_TXEMPTY;
      default: slotCode = ID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/irqid_txpend_ctrl.sv
module irqid_txpend_ctrl
  import irqid_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ieTx,
  input  logic        txFifoEmpty,
  input  logic        iirRead,
  input  logic        thrWrite,
  input  logic        reportTx,
  output ctlStrobes_t strobes
);

  logic prevEmpty;
  logic prevIeTx;
  logic txPend;
  logic setEvt;
  logic clrEvt;

  // A fresh drain, or enabling the source while already empty.
  assign setEvt = (txFifoEmpty && !prevEmpty) || (ieTx && !prevIeTx && txFifoEmpty);
  assign clrEvt = thrWrite || (iirRead && reportTx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevEmpty <= 1'b1;
      prevIeTx  <= 1'b0;
      txPend    <= 1'b0;
    end else begin
      prevEmpty <= txFifoEmpty;
      prevIeTx  <= ieTx;
      if (setEvt)      txPend <= 1'b1;
      else if (clrEvt) txPend <= 1'b0;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.txPend  = txPend;
    strobes.capture = iirRead;
  end

  // R7: a drain of the FIFO raises the flag on the next cycle
  p_set_on_drain_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txFifoEmpty && !prevEmpty) |=> txPend);

  // R7: enabling while empty raises the flag
  p_set_on_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ieTx && !prevIeTx && txFifoEmpty) |=> txPend);

  // R8: holding-register write clears when no set event competes
  p_thr_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrite && !setEvt) |=> !txPend);

  // R8: a read that reports transmit empty clears it
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (iirRead && reportTx && !setEvt) |=> !txPend);

endmodule

// File: rtl/irqid_datapath.sv
module irqid_datapath
  import irqid_pkg::*;
#(
  parameter int ERR_W   = 4,
  parameter int DELTA_W = 4,
  parameter int IE_W    = 4,
  parameter int ID_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IE_W-1:0]    ieMask,
  input  logic [ERR_W-1:0]   lineErr,
  input  logic               rxTrigHit,
  input  logic               rxTimeout,
  input  logic [DELTA_W-1:0] modemDelta,
  input  logic               fifoEn,
  input  ctlStrobes_t        strobes,
  output logic               reportTx,
  output logic               irq,
  output logic [ID_W-1:0]    idLive,
  output logic [ID_W-1:0]    idRead
);

  localparam int CODE_W = 4;
  localparam logic [ID_W-1:0] RESET_ID = ID_W'(ID_NONE);

  logic [NUM_SRC-1:0] srcAct;
  logic [CODE_W-1:0]  winCode;
  logic               anyAct;

  // Masked sources in priority slots, slot 0 highest.
  always_comb begin
    srcAct    = '0;
    srcAct[0] = ieMask[2] && (|lineErr);
    srcAct[1] = ieMask[0] && rxTrigHit;
    srcAct[2] = ieMask[0] && rxTimeout;
    srcAct[3] = ieMask[1] && strobes.txPend;
    srcAct[4] = ieMask[3] && (|modemDelta);
  end

  // Walk from lowest to highest so the highest active slot wins.
  always_comb begin
    winCode = CODE_W'(ID_NONE);
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (srcAct[s]) winCode = slotCode(s);
    end
  end

  assign anyAct   = |srcAct;
  assign irq      = anyAct;
  assign reportTx = (winCode == CODE_W'(ID_TXEMPTY));

  generate
    if (ID_W > 8) begin : g_wide
      assign idLive = {{(ID_W-8){1'b0}}, {2{fifoEn}}, 2'b00, winCode};
    end else begin : g_byte
      assign idLive = {{2{fifoEn}}, 2'b00, winCode};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                idRead <= RESET_ID;
    else if (strobes.capture) idRead <= idLive;
  end

  // R1: line status outranks all others
  p_line_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ieMask[2] && (|lineErr)) |-> (idLive[3:0] == 4'h6));

  // R1: timeout shown only when nothing higher is active
  p_timeout_rank_r1: assert property (@(posedge clk) disable iff (!rstN)
    (idLive[3:0] == 4'hC) |-> !(ieMask[0] && rxTrigHit));

  // R3: no request means the idle code
  p_idle_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    !irq |-> (idLive[3:0] == 4'h1));

  // R4: reserved bits stay zero
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    idLive[5:4] == 2'b00);

  // R10: latched byte holds between reads
  p_hold_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(idRead));

endmodule

// File: rtl/irq_id_unit.sv
module irq_id_unit
  import irqid_pkg::*;
#(
  parameter int ERR_W   = 4,
  parameter int DELTA_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         ieMask,
  input  logic [ERR_W-1:0]   lineErr,
  input  logic               rxTrigHit,
  input  logic               rxTimeout,
  input  logic               txFifoEmpty,
  input  logic [DELTA_W-1:0] modemDelta,
  input  logic               fifoEn,
  input  logic               iirRead,
  input  logic               thrWrite,
  output logic               irq,
  output logic [7:0]         idLive,
  output logic [7:0]         idRead
);

  ctlStrobes_t strobes;
  logic        reportTx;

  irqid_txpend_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ieTx        (ieMask[1]),
    .txFifoEmpty (txFifoEmpty),
    .iirRead     (iirRead),
    .thrWrite    (thrWrite),
    .reportTx    (reportTx),
    .strobes     (strobes)
  );

  irqid_datapath #(
    .ERR_W   (ERR_W),
    .DELTA_W (DELTA_W),
    .IE_W    (4),
    .ID_W    (8)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ieMask     (ieMask),
    .lineErr    (lineErr),
    .rxTrigHit  (rxTrigHit),
    .rxTimeout  (rxTimeout),
    .modemDelta (modemDelta),
    .fifoEn     (fifoEn),
    .strobes    (strobes),
    .reportTx   (reportTx),
    .irq        (irq),
    .idLive     (idLive),
    .idRead     (idRead)
  );

endmodule

// File: tb/irq_id_unit_bench.sv
module irq_id_unit_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] ieMask = '0;
  logic [3:0] lineErr = '0;
  logic       rxTrigHit = 1'b0;
  logic       rxTimeout = 1'b0;
  logic       txFifoEmpty = 1'b1;
  logic [3:0] modemDelta = '0;
  logic       fifoEn = 1'b0;
  logic       iirRead = 1'b0;
  logic       thrWrite = 1'b0;
  logic       irq;
  logic [7:0] idLive;
  logic [7:0] idRead;

  int checks = 0;
  int errors = 0;

  // Bench model state
  logic       mPend = 1'b0;
  logic       mPrevEmpty = 1'b1;
  logic       mPrevIe = 1'b0;
  logic [7:0] mRead = 8'h01;

  irq_id_unit u_irq_id_unit (
    .clk(clk), .rstN(rstN), .ieMask(ieMask), .lineErr(lineErr),
    .rxTrigHit(rxTrigHit), .rxTimeout(rxTimeout), .txFifoEmpty(txFifoEmpty),
    .modemDelta(modemDelta), .fifoEn(fifoEn), .iirRead(iirRead),
    .thrWrite(thrWrite), .irq(irq), .idLive(idLive), .idRead(idRead)
  );

  always #10 clk = ~clk;

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [3:0] expCode();
    if (ieMask[2] && (|lineErr)) return 4'h6;
    if (ieMask[0] && rxTrigHit)  return 4'h4;
    if (ieMask[0] && rxTimeout)  return 4'hC;
    if (ieMask[1] && mPend)      return 4'h2;
    if (ieMask[3] && (|modemDelta)) return 4'h0;
    return 4'h1;
  endfunction

  function automatic logic [7:0] expByte();
    return {fifoEn, fifoEn, 2'b00, expCode()};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: check live outputs, advance model, check latched byte.
  task automatic cycle(input string req);
    logic [7:0] eb;
    logic       setE;
    logic       clrE;
    #2;
    eb = expByte();
    check({req, " live"}, idLive, eb);
    check("R3 irq", {7'd0, irq}, {7'd0, (eb[3:0] != 4'h1)});
    @(posedge clk);
    setE = (txFifoEmpty && !mPrevEmpty) || (ieMask[1] && !mPrevIe && txFifoEmpty);
    clrE = thrWrite || (iirRead && eb[3:0] == 4'h2);
    if (setE) mPend = 1'b1;
    else if (clrE) mPend = 1'b0;
    if (iirRead) mRead = eb;
    mPrevEmpty = txFifoEmpty;
    mPrevIe = ieMask[1];
    @(negedge clk);
    check({req, " read"}, idRead, mRead);
  endtask

  task automatic pulse(input logic rd, input logic wr, input string req);
    iirRead = rd;
    thrWrite = wr;
    cycle(req);
    iirRead = 1'b0;
    thrWrite = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 reset live", idLive, 8'h01);
    check("R11 reset read", idRead, 8'h01);
    check("R11 reset irq", {7'd0, irq}, 8'h00);

    // R4: FIFO-enabled upper bits
    fifoEn = 1'b1;
    #2 check("R4 fifo bits", idLive, 8'hC1);
    cycle("R4");

    // R7: enable rising while empty sets pending
    ieMask = 4'b0010;
    cycle("R7 enable");
    #2 check("R7 pend via enable", idLive, 8'hC2);
    cycle("R7");

    // R8 + R10: read reporting tx clears flag, returns 0xC2
    pulse(1'b1, 1'b0, "R8 read");
    check("R10 latched", idRead, 8'hC2);
    #2 check("R8 cleared by read", idLive, 8'hC1);
    cycle("R8");

    // R7: drain then R8 THR clear
    txFifoEmpty = 1'b0;
    cycle("R7 fill");
    txFifoEmpty = 1'b1;
    cycle("R7 drain");
    #2 check("R7 pend via drain", idLive, 8'hC2);
    pulse(1'b0, 1'b1, "R8 thr");
    #2 check("R8 cleared by thr", idLive, 8'hC1);
    cycle("R8");

    // R8: set and read-clear in the same cycle, set wins
    pulse(1'b1, 1'b0, "R8 idle read");
    txFifoEmpty = 1'b0;
    cycle("R8 fill");
    txFifoEmpty = 1'b1;
    cycle("R8 drain");
    txFifoEmpty = 1'b0;
    cycle("R8 fill2");
    txFifoEmpty = 1'b1;
    pulse(1'b1, 1'b0, "R8 collide");
    check("R8 collide latched", idRead, 8'hC2);
    #2 check("R8 set wins", idLive, 8'hC2);
    cycle("R8");

    // R1 ladder with all sources active
    ieMask = 4'hF; lineErr = 4'b0100; rxTrigHit = 1'b1; rxTimeout = 1'b1; modemDelta = 4'b0001;
    #2 check("R1 line top", idLive, 8'hC6);
    cycle("R1");
    lineErr = '0;
    #2 check("R1 rx next", idLive, 8'hC4);
    cycle("R1");
    rxTrigHit = 1'b0;
    #2 check("R1 timeout next", idLive, 8'hCC);
    cycle("R1");
    rxTimeout = 1'b0;
    #2 check("R1 tx next", idLive, 8'hC2);
    pulse(1'b1, 1'b0, "R1 read tx");
    #2 check("R2 modem code", idLive, 8'hC0);
    cycle("R2");

    // R5: line errors ignored with enable bit 2 off
    ieMask = 4'b1011; lineErr = 4'b1000;
    #2 check("R5 line masked", idLive, 8'hC0);
    cycle("R5");
    ieMask = 4'b1111;
    #2 check("R5 break active", idLive, 8'hC6);
    cycle("R5");
    lineErr = '0;

    // R6: receive and timeout masked by bit 0
    ieMask = 4'b0110; rxTrigHit = 1'b1; rxTimeout = 1'b1; modemDelta = '0;
    #2 check("R6 rx masked", idLive, 8'hC1);
    check("R6 irq low", {7'd0, irq}, 8'h00);
    cycle("R6");
    rxTrigHit = 1'b0; rxTimeout = 1'b0;

    // R9: each modem delta alone
    ieMask = 4'b1000;
    for (int b = 0; b < 4; b++) begin
      modemDelta = 4'(1 << b);
      #2 check("R9 delta", idLive, 8'hC0);
      cycle("R9");
    end
    modemDelta = '0;
    fifoEn = 1'b0;
    #2 check("R4 fifo off", idLive, 8'h01);
    cycle("R4");

    // Random mix against the model
    void'($urandom(32'd20240607));
    for (int n = 0; n < 3000; n++) begin
      ieMask      = 4'($urandom);
      lineErr     = (($urandom % 6) == 0) ? 4'($urandom) : 4'd0;
      rxTrigHit   = (($urandom % 5) == 0);
      rxTimeout   = (($urandom % 6) == 0);
      txFifoEmpty = (($urandom % 3) != 0);
      modemDelta  = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      fifoEn      = 1'($urandom);
      pulse((($urandom % 3) == 0), (($urandom % 5) == 0), "R1 R2 R7 R8 R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule